// File: doc/BRIEF.md
# Ring-Buffer Command Processor

This block is the command front end of an accelerator. Host software sets up a ring of command words in its own memory, tells the block where the ring lives and how large it is through a small register port, and then announces new work by writing the target write offset into a doorbell register. The block fetches the words itself as a bus master over a simple request/response read port with variable latency, decodes them and carries them out.

Commands can load a numbered configuration register of the accelerator, branch into a secondary command buffer and come back to the word after the branch, publish a fence value that the host reads to learn how far execution has got, and raise an interrupt. The block also raises the interrupt when it has consumed everything up to the write offset, so the host may either wait for the interrupt or poll the status register. A malformed stream stops the block with an error flag until the host clears it.

Top module: `cmdproc`

## Requirements
- R1: After reset the status register reads 0, the read offset and fence read 0, `irq_o` is low and no memory read is requested.
- R2: Register word offsets: 0 ring base (word address), 1 ring size as log2 of words, 2 doorbell (write offset), 3 read offset (read only), 4 fence (read only), 5 status with bit 0 busy, bit 1 error, bit 2 interrupt pending. Writing the base register resets the read and write offsets to 0.
- R3: A doorbell write whose offset differs from the read offset starts execution; busy reads 1 while commands run; a doorbell written while busy replaces the target, and execution stops only at the latest target.
- R4: At most one memory read is outstanding; each request lasts one cycle and the block waits for `mem_rvalid_i` before using the word. Ring words are read from base plus read offset.
- R5: A command is a header word with the opcode in bits 31:24 (0 no-op, 1 register write, 2 call, 3 fence, 4 interrupt) and payload words after it. A register write takes the register index from header bits 7:0 and the value from the next word and gives one `cfg_we_o` pulse; writes appear in stream order.
- R6: The read offset advances modulo 2^size, so fetching wraps from the last ring word back to the base.
- R7: A call takes a word address and a length in words; the block executes that many words from the address and then continues with the ring word after the call's payload.
- R8: A fence command stores its payload word, readable at the fence register.
- R9: The interrupt command, and reaching the write offset outside a secondary buffer, set the interrupt pending bit; `irq_o` stays high until the host writes 1 to status bit 2.
- R10: An unknown opcode, or a call inside a secondary buffer, sets the error bit and halts with no further fetch; writing 1 to status bit 1 clears the error, discards the remaining work (read offset becomes the write offset) and leaves the secondary buffer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_we_i | input | 1 | Host register write strobe |
| reg_addr_i | input | 3 | Host register word offset (read and write) |
| reg_wdata_i | input | 32 | Host write data |
| reg_rdata_o | output | 32 | Host read data for `reg_addr_i` |
| mem_req_o | output | 1 | Memory read request, one cycle |
| mem_addr_o | output | AW | Memory word address |
| mem_rvalid_i | input | 1 | Memory read data valid |
| mem_rdata_i | input | 32 | Memory read data |
| cfg_we_o | output | 1 | Configuration register write pulse |
| cfg_idx_o | output | 8 | Configuration register index |
| cfg_data_o | output | 32 | Configuration register value |
| irq_o | output | 1 | Interrupt, high while pending |

## Verification
The bench walks the ring across its wrap point with the payload of one command on each side of it; a design that did not mask the offset would read past the ring into filler words that decode as illegal opcodes. A second doorbell is rung while the first batch is still running, so a design that latched only the first target would stop early and raise the interrupt at the wrong place. Secondary-buffer return is checked by the order of configuration writes, which a design returning to the wrong word would scramble, and a nested call plus an illegal opcode must each halt with no further fetch and the read offset exactly one past the bad header. Memory latency rotates between one and four cycles so any design that decodes before `mem_rvalid_i` would act on stale data.

// File: rtl/cmdproc_pkg.sv
package cmdproc_pkg;
  typedef enum logic [7:0] {
    OP_NOP  = 8'd0,
    OP_REGW = 8'd1,
    OP_CALL = 8'd2,
    OP_FNC  = 8'd3,
    OP_INT  = 8'd4
  } op_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_NEXT, ST_REQ, ST_WAIT, ST_HALT
  } state_e;

  typedef enum logic [1:0] {PH_HDR, PH_ARG1, PH_ARG2} phase_e;

  localparam logic [2:0] RA_BASE = 3'd0;
  localparam logic [2:0] RA_SIZE = 3'd1;
  localparam logic [2:0] RA_DB   = 3'd2;
  localparam logic [2:0] RA_RPTR = 3'd3;
  localparam logic [2:0] RA_FNC  = 3'd4;
  localparam logic [2:0] RA_STAT = 3'd5;
endpackage

// File: rtl/cp_regs.sv
module cp_regs
  import cmdproc_pkg::*;
#(
  parameter int AW = 16,
  localparam int SW = $clog2(AW + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [2:0]    addr_i,
  input  logic [31:0]   wdata_i,
  output logic [31:0]   rdata_o,
  output logic [AW-1:0] base_o,
  output logic [AW-1:0] mask_o,
  output logic [AW-1:0] wptr_o,
  output logic          base_wr_o,
  output logic          irq_clr_o,
  output logic          err_clr_o,
  input  logic [AW-1:0] rptr_i,
  input  logic [31:0]   fence_i,
  input  logic          busy_i,
  input  logic          err_i,
  input  logic          irq_i
);
  logic [SW-1:0] size_q;

  assign mask_o    = ~({AW{1'b1}} << size_q);
  assign base_wr_o = we_i && addr_i == RA_BASE;
  assign irq_clr_o = we_i && addr_i == RA_STAT && wdata_i[2];
  assign err_clr_o = we_i && addr_i == RA_STAT && wdata_i[1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_o <= '0;
      size_q <= '0;
      wptr_o <= '0;
    end else if (we_i) begin
      case (addr_i)
        RA_BASE: begin
          base_o <= wdata_i[AW-1:0];
          wptr_o <= '0;
        end
        RA_SIZE: size_q <= wdata_i[SW-1:0];
        RA_DB:   wptr_o <= wdata_i[AW-1:0] & mask_o;
        default: ;
      endcase
    end
  end

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      RA_BASE: rdata_o[AW-1:0] = base_o;
      RA_SIZE: rdata_o[SW-1:0] = size_q;
      RA_DB:   rdata_o[AW-1:0] = wptr_o;
      RA_RPTR: rdata_o[AW-1:0] = rptr_i;
      RA_FNC:  rdata_o         = fence_i;
      RA_STAT: rdata_o[2:0]    = {irq_i, err_i, busy_i};
      default: ;
    endcase
  end
endmodule

// File: rtl/cp_engine.sv
module cp_engine
  import cmdproc_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] base_i,
  input  logic [AW-1:0] mask_i,
  input  logic [AW-1:0] wptr_i,
  input  logic          base_wr_i,
  input  logic          irq_clr_i,
  input  logic          err_clr_i,
  output logic          mem_req_o,
  output logic [AW-1:0] mem_addr_o,
  input  logic          mem_rvalid_i,
  input  logic [31:0]   mem_rdata_i,
  output logic          cfg_we_o,
  output logic [7:0]    cfg_idx_o,
  output logic [31:0]   cfg_data_o,
  output logic [AW-1:0] rptr_o,
  output logic [31:0]   fence_o,
  output logic          busy_o,
  output logic          err_o,
  output logic          irq_o
);
  state_e        state_q;
  phase_e        phase_q;
  logic [7:0]    op_q;
  logic [AW-1:0] ib_ptr_q, ib_end_q, call_addr_q;
  logic          in_ib_q;
  logic [7:0]    rop;

  assign rop        = mem_rdata_i[31:24];
  assign mem_req_o  = state_q == ST_REQ;
  assign mem_addr_o = in_ib_q ? ib_ptr_q : base_i + rptr_o;
  assign busy_o     = state_q inside {ST_NEXT, ST_REQ, ST_WAIT};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      phase_q     <= PH_HDR;
      op_q        <= '0;
      ib_ptr_q    <= '0;
      ib_end_q    <= '0;
      call_addr_q <= '0;
      in_ib_q     <= 1'b0;
      rptr_o      <= '0;
      fence_o     <= '0;
      err_o       <= 1'b0;
      irq_o       <= 1'b0;
      cfg_we_o    <= 1'b0;
      cfg_idx_o   <= '0;
      cfg_data_o  <= '0;
    end else begin
      cfg_we_o <= 1'b0;
      if (irq_clr_i) irq_o <= 1'b0;
      case (state_q)
        ST_IDLE: if (rptr_o != wptr_i && !base_wr_i) state_q <= ST_NEXT;
        ST_NEXT: begin
          if (in_ib_q && ib_ptr_q == ib_end_q) begin
            in_ib_q <= 1'b0;
          end else if (!in_ib_q && rptr_o == wptr_i) begin
            irq_o   <= 1'b1;
            state_q <= ST_IDLE;
          end else begin
            phase_q <= PH_HDR;
            state_q <= ST_REQ;
          end
        end
        ST_REQ: state_q <= ST_WAIT;
        ST_WAIT: if (mem_rvalid_i) begin
          if (in_ib_q) ib_ptr_q <= ib_ptr_q + 1'b1;
          else         rptr_o   <= (rptr_o + 1'b1) & mask_i;
          state_q <= ST_NEXT;
          case (phase_q)
            PH_HDR: begin
              op_q      <= rop;
              cfg_idx_o <= mem_rdata_i[7:0];
              case (rop)
                OP_NOP: ;
                OP_REGW, OP_FNC: begin
                  phase_q <= PH_ARG1;
                  state_q <= ST_REQ;
                end
                OP_CALL: begin
                  if (in_ib_q) begin
                    err_o   <= 1'b1;
                    state_q <= ST_HALT;
                  end else begin
                    phase_q <= PH_ARG1;
                    state_q <= ST_REQ;
                  end
                end
                OP_INT: irq_o <= 1'b1;
                default: begin
                  err_o   <= 1'b1;
                  state_q <= ST_HALT;
                end
              endcase
            end
            PH_ARG1: begin
              if (op_q == OP_REGW) begin
                cfg_we_o   <= 1'b1;
                cfg_data_o <= mem_rdata_i;
              end else if (op_q == OP_FNC) begin
                fence_o <= mem_rdata_i;
              end else begin
                call_addr_q <= mem_rdata_i[AW-1:0];
                phase_q     <= PH_ARG2;
                state_q     <= ST_REQ;
              end
            end
            default: begin
              ib_ptr_q <= call_addr_q;
              ib_end_q <= call_addr_q + mem_rdata_i[AW-1:0];
              in_ib_q  <= 1'b1;
            end
          endcase
        end
        ST_HALT: if (err_clr_i) begin
          err_o   <= 1'b0;
          in_ib_q <= 1'b0;
          rptr_o  <= wptr_i;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
      if (base_wr_i) rptr_o <= '0;
    end
  end
endmodule

// File: rtl/cmdproc.sv
module cmdproc
  import cmdproc_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          reg_we_i,
  input  logic [2:0]    reg_addr_i,
  input  logic [31:0]   reg_wdata_i,
  output logic [31:0]   reg_rdata_o,
  output logic          mem_req_o,
  output logic [AW-1:0] mem_addr_o,
  input  logic          mem_rvalid_i,
  input  logic [31:0]   mem_rdata_i,
  output logic          cfg_we_o,
  output logic [7:0]    cfg_idx_o,
  output logic [31:0]   cfg_data_o,
  output logic          irq_o
);
  logic [AW-1:0] base_w, mask_w, wptr_w, rptr_w;
  logic          base_wr_w, irq_clr_w, err_clr_w, busy_w, err_w;
  logic [31:0]   fence_w;

  cp_regs #(.AW(AW)) u_regs (
    .clk_i, .rst_ni,
    .we_i(reg_we_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i), .rdata_o(reg_rdata_o),
    .base_o(base_w), .mask_o(mask_w), .wptr_o(wptr_w),
    .base_wr_o(base_wr_w), .irq_clr_o(irq_clr_w), .err_clr_o(err_clr_w),
    .rptr_i(rptr_w), .fence_i(fence_w), .busy_i(busy_w), .err_i(err_w), .irq_i(irq_o)
  );

  cp_engine #(.AW(AW)) u_eng (
    .clk_i, .rst_ni,
    .base_i(base_w), .mask_i(mask_w), .wptr_i(wptr_w),
    .base_wr_i(base_wr_w), .irq_clr_i(irq_clr_w), .err_clr_i(err_clr_w),
    .mem_req_o, .mem_addr_o, .mem_rvalid_i, .mem_rdata_i,
    .cfg_we_o, .cfg_idx_o, .cfg_data_o,
    .rptr_o(rptr_w), .fence_o(fence_w), .busy_o(busy_w), .err_o(err_w), .irq_o
  );
endmodule

// File: rtl/cmdproc_chk.sv
module cmdproc_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       mem_req,
  input logic       mem_rvalid,
  input logic       cfg_we,
  input logic       irq,
  input logic       busy,
  input logic       err,
  input logic       reg_we,
  input logic [2:0] reg_addr,
  input logic       wbit2,
  input logic       wbit1
);
  logic outst_q;
  logic irq_clr, err_clr;

  assign irq_clr = reg_we && reg_addr == 3'd5 && wbit2;
  assign err_clr = reg_we && reg_addr == 3'd5 && wbit1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         outst_q <= 1'b0;
    else if (mem_req)    outst_q <= 1'b1;
    else if (mem_rvalid) outst_q <= 1'b0;
  end

  AST_ONE_OUTSTANDING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mem_req && outst_q)); // R4
  AST_REQ_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req |=> !mem_req); // R4
  AST_CFG_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_we |=> !cfg_we); // R5
  AST_IRQ_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq && !irq_clr) |=> irq); // R9
  AST_IRQ_AT_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(busy) && !err) |-> irq); // R9
  AST_HALT_NO_FETCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err |-> !mem_req); // R10
  AST_ERR_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err && !err_clr) |=> err); // R10
endmodule

bind cmdproc cmdproc_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni),
  .mem_req(mem_req_o), .mem_rvalid(mem_rvalid_i), .cfg_we(cfg_we_o), .irq(irq_o),
  .busy(busy_w), .err(err_w),
  .reg_we(reg_we_i), .reg_addr(reg_addr_i), .wbit2(reg_wdata_i[2]), .wbit1(reg_wdata_i[1])
);

// File: tb/cmdproc_tb.sv
module cmdproc_tb;
  localparam int AW = 16;
  localparam logic [31:0] BASE = 32'h40;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          reg_we = 1'b0;
  logic [2:0]    reg_addr = '0;
  logic [31:0]   reg_wdata = '0;
  logic [31:0]   reg_rdata;
  logic          mem_req;
  logic [AW-1:0] mem_addr;
  logic          mem_rvalid = 1'b0;
  logic [31:0]   mem_rdata = '0;
  logic          cfg_we;
  logic [7:0]    cfg_idx;
  logic [31:0]   cfg_data;
  logic          irq;

  int errors = 0;
  int checks = 0;
  logic [31:0] mem [0:255];
  logic [39:0] exp_q [$];
  int lat_cnt = 0;

  always #2 clk = ~clk;

  cmdproc #(.AW(AW)) u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .reg_we_i(reg_we), .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
    .mem_req_o(mem_req), .mem_addr_o(mem_addr), .mem_rvalid_i(mem_rvalid), .mem_rdata_i(mem_rdata),
    .cfg_we_o(cfg_we), .cfg_idx_o(cfg_idx), .cfg_data_o(cfg_data), .irq_o(irq)
  );

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", r, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic expect_cfg(input logic [7:0] idx, input logic [31:0] val);
    exp_q.push_back({idx, val});
  endtask

  task automatic wait_stop();
    logic [31:0] s;
    repeat (2) @(negedge clk);
    for (int i = 0; i < 2000; i++) begin
      rd(3'd5, s);
      if (!s[0]) break;
      @(negedge clk);
    end
  endtask

  // memory model: latency rotates 1..4 cycles
  initial begin
    forever begin
      @(negedge clk);
      mem_rvalid = 1'b0;
      if (mem_req) begin
        logic [7:0] a;
        a = mem_addr[7:0];
        repeat (lat_cnt % 4) @(negedge clk);
        lat_cnt++;
        @(negedge clk);
        mem_rvalid = 1'b1;
        mem_rdata  = mem[a];
      end
    end
  end

  // scoreboard monitor for configuration writes (R5)
  always @(negedge clk) begin
    if (rst_n && cfg_we) begin
      if (exp_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R5: unexpected cfg write actual=%h_%h expected=none", cfg_idx, cfg_data);
      end else begin
        logic [39:0] e;
        e = exp_q.pop_front();
        chk("R5 cfg write", {cfg_idx, cfg_data[23:0]}, {e[39:32], e[23:0]});
        chk("R5 cfg data", cfg_data, e[31:0]);
      end
    end
  end

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    logic [31:0] d;
    for (int i = 0; i < 256; i++) mem[i] = 32'hFF00_0000;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(3'd5, d); chk("R1 status", d, 0);
    rd(3'd3, d); chk("R1 rptr", d, 0);
    rd(3'd4, d); chk("R1 fence", d, 0);
    chk("R1 irq", {31'd0, irq}, 0);
    chk("R1 mem_req", {31'd0, mem_req}, 0);

    // R2 setup
    wr(3'd0, BASE);
    wr(3'd1, 32'd4);
    rd(3'd0, d); chk("R2 base readback", d, BASE);
    rd(3'd1, d); chk("R2 size readback", d, 4);

    // R5, R8, R9: regwr, nop, fence
    mem[BASE+0] = 32'h0100_0003; mem[BASE+1] = 32'hA5A5_0001;
    mem[BASE+2] = 32'h0000_0000;
    mem[BASE+3] = 32'h0300_0000; mem[BASE+4] = 32'h0000_0011;
    expect_cfg(8'h03, 32'hA5A5_0001);
    wr(3'd2, 32'd5);
    wait_stop();
    rd(3'd4, d); chk("R8 fence", d, 32'h11);
    rd(3'd3, d); chk("R3 rptr at wptr", d, 5);
    rd(3'd5, d); chk("R9 status irq pending", d, 4);
    chk("R9 irq_o", {31'd0, irq}, 1);
    wr(3'd5, 32'd4);
    rd(3'd5, d); chk("R9 irq cleared", d, 0);
    chk("R9 irq_o low", {31'd0, irq}, 0);

    // R7 call into secondary buffer, then resume
    mem[BASE+5] = 32'h0200_0000; mem[BASE+6] = 32'h80; mem[BASE+7] = 32'd3;
    mem[8'h80] = 32'h0100_0007; mem[8'h81] = 32'h0000_B0B0; mem[8'h82] = 32'h0;
    mem[BASE+8] = 32'h0100_0009; mem[BASE+9] = 32'h0000_D0D0;
    expect_cfg(8'h07, 32'hB0B0);
    expect_cfg(8'h09, 32'hD0D0);
    wr(3'd2, 32'd10);
    @(negedge clk);
    rd(3'd5, d); chk("R3 busy while running", {31'd0, d[0]}, 1);
    wait_stop();
    rd(3'd3, d); chk("R7 rptr after return", d, 10);
    chk("R7 cfg queue drained", exp_q.size(), 0);
    wr(3'd5, 32'd4);

    // R3 + R6: doorbell while busy, wrap across ring end
    for (int i = 10; i < 14; i++) mem[BASE+i] = 32'h0;
    mem[BASE+14] = 32'h0100_000E; mem[BASE+15] = 32'h0000_E0E0;
    mem[BASE+0]  = 32'h0100_0010; mem[BASE+1]  = 32'h0000_F0F0;
    expect_cfg(8'h0E, 32'hE0E0);
    expect_cfg(8'h10, 32'hF0F0);
    wr(3'd2, 32'd12);
    wr(3'd2, 32'd2);
    wait_stop();
    rd(3'd3, d); chk("R6 rptr wrapped", d, 2);
    chk("R3 all commands up to latest target", exp_q.size(), 0);
    rd(3'd5, d); chk("R3 idle no error", d, 4);
    wr(3'd5, 32'd4);

    // R9 interrupt command mid-stream
    mem[BASE+2] = 32'h0400_0000;
    for (int i = 3; i < 7; i++) mem[BASE+i] = 32'h0;
    wr(3'd2, 32'd7);
    for (int i = 0; i < 500; i++) begin
      if (irq) break;
      @(negedge clk);
    end
    rd(3'd3, d); chk("R9 irq on interrupt command", d, 3);
    rd(3'd5, d); chk("R9 still busy at command irq", {31'd0, d[0]}, 1);
    wait_stop();
    rd(3'd3, d); chk("R9 rptr end", d, 7);
    wr(3'd5, 32'd4);

    // R10 nested call
    mem[BASE+7] = 32'h0200_0000; mem[BASE+8] = 32'h90; mem[BASE+9] = 32'd2;
    mem[8'h90] = 32'h0200_0000; mem[8'h91] = 32'h0;
    mem[BASE+10] = 32'h0100_0020; mem[BASE+11] = 32'h0000_2020;
    wr(3'd2, 32'd12);
    wait_stop();
    rd(3'd5, d); chk("R10 nested call error", d, 2);
    begin
      int reqs = 0;
      for (int i = 0; i < 20; i++) begin
        @(negedge clk);
        if (mem_req) reqs++;
      end
      chk("R10 no fetch while halted", reqs, 0);
    end
    wr(3'd5, 32'd2);
    rd(3'd5, d); chk("R10 error cleared", d, 0);
    rd(3'd3, d); chk("R10 rptr discards work", d, 12);

    // R10 unknown opcode
    mem[BASE+12] = 32'h5500_0000;
    mem[BASE+13] = 32'h0100_0021; mem[BASE+14] = 32'h0000_2121;
    wr(3'd2, 32'd15);
    wait_stop();
    rd(3'd5, d); chk("R10 unknown opcode error", d, 2);
    rd(3'd3, d); chk("R10 rptr one past bad header", d, 13);
    wr(3'd5, 32'd2);
    rd(3'd3, d); chk("R10 rptr after clear", d, 15);
    repeat (10) @(negedge clk);
    chk("R10 skipped commands not executed", exp_q.size(), 0);

    // R2 base write resets offsets
    wr(3'd0, BASE);
    rd(3'd3, d); chk("R2 rptr reset by base write", d, 0);
    rd(3'd2, d); chk("R2 wptr reset by base write", d, 0);
    repeat (5) @(negedge clk);
    rd(3'd5, d); chk("R2 stays idle", d, 0);

    finish_run();
  end
endmodule